// File: doc/BRIEF.md
# Trace Buffer Pointer and Threshold Controller

This block owns a single-ported circular store of trace entries and the read and write pointers around it. A capture strobe appends an entry at the write pointer. A patch request overwrites the payload of an entry that is already stored, so that data arriving late can be merged in. A read request returns the oldest unread entry with a two-bit state field in its top bits. The three sources share the one memory port through a fixed priority. Reads return an invalid marker when nothing is stored. Captures that arrive while the store is full are dropped. The first entry stored once room is free again is tagged to show the gap.

A four-state machine tracks tracing. `S_OFF` means tracing is disabled, and captures are ignored. `S_TRACE` is normal capture. `S_OVER` means a capture was lost to a full store, and all captures are dropped. `S_RECOVER` means room has been freed after a loss, and the next stored entry carries the discontinuity tag. The transitions are:
- Enable: `S_OFF` goes to `S_TRACE` on a rising edge of `trace_en`, and both pointers clear.
- Loss: `S_TRACE` goes to `S_OVER` when a capture arrives while full.
- Drain: `S_OVER` goes to `S_RECOVER` once the store is no longer full.
- Resume: `S_RECOVER` goes to `S_TRACE` when a tagged capture is stored. If the store is full again, it goes back to `S_OVER`.
- Disable: any state goes to `S_OFF` whenever `trace_en` is low.

Fullness is the distance from the read pointer to the write pointer. Three interrupts pulse when that distance climbs to one half, three quarters and all of the capacity. Each interrupt has its own enable.

Top module: `trace_ptr_ctrl`

## Requirements
- R1: After reset, `rd_done`, `rd_ack`, `patch_ack` and `thr_irq` are 0. On each rising edge of `trace_en`, both pointers return to entry 0, which discards everything stored.
- R2: Each capture taken in `S_TRACE` or `S_RECOVER` is stored at the write pointer. Reads return entries oldest first, and each read of a stored entry advances the read pointer.
- R3: The memory port goes to the capture write first, then the patch, then the read. `patch_ack` and `rd_ack` are combinational grants, and a request that is not granted waits.
- R4: A capture that arrives while 2^ADDR_W entries are stored is dropped and the machine enters `S_OVER`. Every capture is then dropped until a cycle after a read has left the store short of full.
- R5: The first entry stored in `S_RECOVER` reads back with state bits [63:62] = 2'b11. All other stored entries read back with 2'b10, including entries written after the store was full without any loss.
- R6: A read granted while nothing is stored returns an all-zero word, so its state bits are 2'b00. The read pointer does not move, so the next stored entry is the next one read.
- R7: `thr_irq[0]`, `thr_irq[1]` and `thr_irq[2]` pulse for one cycle in the cycle after a capture write brings the fill level to 1/2, 3/4 and all of capacity. Each pulses only if the matching `thr_en` bit is 1, and it pulses again every time its level is reached.
- R8: A granted patch replaces payload bits [61:0] of the entry at `patch_idx`. It leaves that entry's state tag unchanged.
- R9: `rd_done` is high for exactly the one cycle after a read grant. `rd_data` holds its value until the next read completes.
- R10: While `trace_en` is low, captures are ignored and reads still return stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing enable; a rising edge clears both pointers |
| thr_en | input | 3 | Per-level interrupt enables (half, three quarters, full) |
| cap_valid | input | 1 | Capture strobe |
| cap_data | input | DATA_W-2 | Payload of the captured entry |
| patch_req | input | 1 | Patch request, held until acknowledged |
| patch_idx | input | ADDR_W | Entry index to patch |
| patch_data | input | DATA_W-2 | Replacement payload |
| patch_ack | output | 1 | Patch granted this cycle |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_ack | output | 1 | Read granted this cycle |
| rd_done | output | 1 | Read response valid |
| rd_data | output | DATA_W | State bits [63:62] and payload of the response |
| thr_irq | output | 3 | Threshold interrupt pulses |

## Verification
On every cycle, the embedded properties check the following:
- At most one memory grant is given.
- The fill level never exceeds capacity.
- An enable edge empties the store.
- Empty reads and captures in `S_OVER` leave the pointers alone.
- A tagged write leads to `S_TRACE`.
- Each interrupt matches the fill level and its enable.
- Each grant is followed by a response.

Only the bench scenarios can show the data-level effects. These are the in-order contents, the exact entry that carries the 2'b11 tag, the fact that dropped captures never appear, and that a patch lands on the right entry. They also include the interrupt pattern over repeated fills with different enable masks.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        S_OFF     = 2'd0,
        S_TRACE   = 2'd1,
        S_OVER    = 2'd2,
        S_RECOVER = 2'd3
    } trc_state_e;

    localparam logic [1:0] TAG_NONE = 2'b00;
    localparam logic [1:0] TAG_OK   = 2'b10;
    localparam logic [1:0] TAG_GAP  = 2'b11;
endpackage

// File: rtl/trc_mem.sv
module trc_mem #(
    parameter int ADDR_W = 4,
    parameter int PAY_W  = 62
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_pay,
    input  logic              we_flag,
    input  logic [PAY_W-1:0]  wpay,
    input  logic              wflag,
    input  logic              re,
    output logic [PAY_W-1:0]  rpay,
    output logic              rflag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [PAY_W-1:0] pay_mem [DEPTH];
    logic [DEPTH-1:0] flag_bits;

    always_ff @(posedge clk) begin
        if (we_pay)
            pay_mem[addr] <= wpay;
        if (we_flag)
            flag_bits[addr] <= wflag;
        if (re) begin
            rpay  <= pay_mem[addr];
            rflag <= flag_bits[addr];
        end
    end
endmodule

// File: rtl/trc_arb.sv
module trc_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_wr,
    input  logic hold,
    input  logic patch_req,
    input  logic rd_req,
    output logic patch_gnt,
    output logic rd_gnt
);
    always_comb begin
        patch_gnt = patch_req & ~cap_wr & ~hold;
        rd_gnt    = rd_req & ~cap_wr & ~patch_req & ~hold;
    end

    // R3
    one_port_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_wr, patch_gnt, rd_gnt}));
endmodule

// File: rtl/trc_ptr.sv
module trc_ptr #(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_inc,
    input  logic            rd_inc,
    input  logic [2:0]      thr_en,
    output logic [ADDR_W:0] wptr,
    output logic [ADDR_W:0] rptr,
    output logic            full,
    output logic            empty,
    output logic [2:0]      thr_irq
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(DEPTH);

    logic [ADDR_W:0] count;
    logic [ADDR_W:0] count_inc;

    always_comb begin
        count     = wptr - rptr;
        count_inc = count + 1'b1;
        full      = (count == CAP);
        empty     = (count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_inc) wptr <= wptr + 1'b1;
            if (rd_inc) rptr <= rptr + 1'b1;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_lvl
        localparam logic [ADDR_W:0] LVL =
            (g == 0) ? (ADDR_W+1)'(DEPTH / 2) :
            (g == 1) ? (ADDR_W+1)'((3 * DEPTH) / 4) : CAP;
        logic hit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hit_q <= 1'b0;
            else
                hit_q <= thr_en[g] & wr_inc & ~clr & (count_inc == LVL);
        end
        assign thr_irq[g] = hit_q;

        // R7
        irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_q |-> (count == LVL) && $past(thr_en[g]));
    end

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

    // R1
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wptr == '0) && (rptr == '0));
endmodule

// File: rtl/trace_ptr_ctrl.sv
module trace_ptr_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic [2:0]        thr_en,
    input  logic              cap_valid,
    input  logic [DATA_W-3:0] cap_data,
    input  logic              patch_req,
    input  logic [ADDR_W-1:0] patch_idx,
    input  logic [DATA_W-3:0] patch_data,
    output logic              patch_ack,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        thr_irq
);
    import trc_pkg::*;

    localparam int PAY_W = DATA_W - 2;

    trc_state_e      state_q, state_d;
    logic            en_q, en_rise;
    logic            cap_wr, gap_tag;
    logic            rd_gnt, patch_gnt;
    logic [ADDR_W:0] wptr, rptr;
    logic            full, empty;
    logic [ADDR_W-1:0] mem_addr;
    logic [PAY_W-1:0]  mem_wpay, mem_rpay;
    logic            mem_rflag;
    logic            rd_done_q, rd_ok_q;

    assign en_rise = trace_en & ~en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= trace_en;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!trace_en)
            state_d = S_OFF;
        else begin
            unique case (state_q)
                S_OFF:     if (en_rise) state_d = S_TRACE;
                S_TRACE:   if (cap_valid && full) state_d = S_OVER;
                S_OVER:    if (!full) state_d = S_RECOVER;
                S_RECOVER: if (cap_valid) state_d = full ? S_OVER : S_TRACE;
                default:   state_d = S_OFF;
            endcase
        end
    end

    always_comb begin
        cap_wr  = 1'b0;
        gap_tag = 1'b0;
        unique case (state_q)
            S_TRACE:   cap_wr = trace_en & cap_valid & ~full;
            S_RECOVER: begin
                cap_wr  = trace_en & cap_valid & ~full;
                gap_tag = 1'b1;
            end
            default: ;
        endcase
    end

    trc_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_wr    (cap_wr),
        .hold      (en_rise),
        .patch_req (patch_req),
        .rd_req    (rd_req),
        .patch_gnt (patch_gnt),
        .rd_gnt    (rd_gnt)
    );

    trc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (en_rise),
        .wr_inc  (cap_wr),
        .rd_inc  (rd_gnt & ~empty),
        .thr_en  (thr_en),
        .wptr    (wptr),
        .rptr    (rptr),
        .full    (full),
        .empty   (empty),
        .thr_irq (thr_irq)
    );

    always_comb begin
        if (cap_wr) begin
            mem_addr = wptr[ADDR_W-1:0];
            mem_wpay = cap_data;
        end else if (patch_gnt) begin
            mem_addr = patch_idx;
            mem_wpay = patch_data;
        end else begin
            mem_addr = rptr[ADDR_W-1:0];
            mem_wpay = patch_data;
        end
    end

    trc_mem #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_mem (
        .clk     (clk),
        .addr    (mem_addr),
        .we_pay  (cap_wr | patch_gnt),
        .we_flag (cap_wr),
        .wpay    (mem_wpay),
        .wflag   (gap_tag),
        .re      (rd_gnt & ~empty),
        .rpay    (mem_rpay),
        .rflag   (mem_rflag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_done_q <= 1'b0;
            rd_ok_q   <= 1'b0;
        end else begin
            rd_done_q <= rd_gnt;
            if (rd_gnt) rd_ok_q <= ~empty;
        end
    end

    assign patch_ack = patch_gnt;
    assign rd_ack    = rd_gnt;
    assign rd_done   = rd_done_q;
    assign rd_data   = rd_ok_q ? {(mem_rflag ? TAG_GAP : TAG_OK), mem_rpay}
                               : {TAG_NONE, {PAY_W{1'b0}}};

    // R6
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt && empty |=> $stable(rptr));

    // R4
    over_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OVER) && cap_valid |=> $stable(wptr));

    // R5
    gap_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RECOVER) && cap_wr |=> (state_q == S_TRACE));

    // R9
    read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> rd_done);
endmodule

// File: tb/trace_ptr_ctrl_tb.sv
module trace_ptr_ctrl_tb;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 1'b0;
    logic [2:0] thr_en = '0;
    logic cap_valid = 1'b0;
    logic [61:0] cap_data = '0;
    logic patch_req = 1'b0;
    logic [AW-1:0] patch_idx = '0;
    logic [61:0] patch_data = '0;
    logic patch_ack, rd_req, rd_ack, rd_done;
    logic [63:0] rd_data;
    logic [2:0] thr_irq;

    int checks = 0;
    int errors = 0;

    initial rd_req = 1'b0;
    always #5 clk = ~clk;

    trace_ptr_ctrl #(.ADDR_W(AW), .DATA_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .thr_en(thr_en),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .patch_req(patch_req), .patch_idx(patch_idx), .patch_data(patch_data),
        .patch_ack(patch_ack), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_done(rd_done), .rd_data(rd_data), .thr_irq(thr_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cap(input logic [61:0] d, output logic [2:0] irq);
        @(negedge clk);
        cap_valid = 1'b1;
        cap_data  = d;
        @(negedge clk);
        irq = thr_irq;
        cap_valid = 1'b0;
    endtask

    task automatic rd(output logic [63:0] d);
        @(negedge clk);
        rd_req = 1'b1;
        #1;
        while (!rd_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_done === 1'b1, "R9 done pulse", {63'd0, rd_done}, 64'd1);
        d = rd_data;
    endtask

    task automatic patch(input logic [AW-1:0] idx, input logic [61:0] d);
        @(negedge clk);
        patch_req = 1'b1;
        patch_idx = idx;
        patch_data = d;
        #1;
        while (!patch_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        patch_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] ent(input logic [1:0] tag, input logic [61:0] p);
        return {tag, p};
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] irq;
        logic [63:0] d;
        logic [2:0] exp_irq;

        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(rd_done === 1'b0 && rd_ack === 1'b0 && patch_ack === 1'b0 && thr_irq === 3'b0,
            "R1 reset outputs", {57'd0, rd_done, rd_ack, patch_ack, thr_irq, 1'b0}, 64'd0);

        // R10 captures ignored while disabled
        for (int i = 0; i < 3; i++) cap(62'h3A0 + 62'(i), irq);
        rd(d);
        chk(d === 64'd0, "R10 capture while off ignored", d, 64'd0);

        // R1 enable
        @(negedge clk); trace_en = 1'b1; thr_en = 3'b111;
        idle(1);

        // R7 fill with all levels enabled
        for (int i = 0; i < DEPTH; i++) begin
            cap(62'h100 + 62'(i), irq);
            exp_irq = {(i + 1 == DEPTH), (i + 1 == (3 * DEPTH) / 4), (i + 1 == DEPTH / 2)};
            chk(irq === exp_irq, "R7 threshold pulse", {61'd0, irq}, {61'd0, exp_irq});
            @(negedge clk);
            chk(thr_irq === 3'b0, "R7 one-cycle pulse", {61'd0, thr_irq}, 64'd0);
        end

        // R4 drop while full
        cap(62'hDEAD, irq);
        chk(irq === 3'b0, "R4 dropped capture no irq", {61'd0, irq}, 64'd0);
        rd(d);
        chk(d === ent(2'b10, 62'h100), "R2 first entry", d, ent(2'b10, 62'h100));
        @(negedge clk);
        chk(rd_done === 1'b0 && rd_data === ent(2'b10, 62'h100), "R9 single pulse and hold",
            rd_data, ent(2'b10, 62'h100));
        idle(2);

        // R5 tagged entry then R8 patch keeps tag
        cap(62'h5A5A, irq);
        patch(3'd0, 62'h7777);
        for (int i = 1; i < DEPTH; i++) begin
            rd(d);
            chk(d === ent(2'b10, 62'h100 + 62'(i)), "R2 R4 in-order entries, no dropped data",
                d, ent(2'b10, 62'h100 + 62'(i)));
        end
        rd(d);
        chk(d === ent(2'b11, 62'h7777), "R5 R8 discontinuity tag survives patch",
            d, ent(2'b11, 62'h7777));

        // R6 underflow
        rd(d);
        chk(d === 64'd0, "R6 empty read invalid", d, 64'd0);
        cap(62'h9999, irq);
        rd(d);
        chk(d === ent(2'b10, 62'h9999), "R6 pointer held on empty read", d, ent(2'b10, 62'h9999));

        // R7 masked levels, repeated firing
        thr_en = 3'b010;
        for (int i = 0; i < DEPTH; i++) begin
            cap(62'h200 + 62'(i), irq);
            exp_irq = {1'b0, (i + 1 == (3 * DEPTH) / 4), 1'b0};
            chk(irq === exp_irq, "R7 masked threshold", {61'd0, irq}, {61'd0, exp_irq});
        end
        thr_en = 3'b100;
        rd(d);
        chk(d === ent(2'b10, 62'h200), "R2 refill first entry", d, ent(2'b10, 62'h200));
        idle(2);
        cap(62'h4444, irq);
        chk(irq === 3'b100, "R7 full level again", {61'd0, irq}, 64'd4);
        for (int i = 1; i < DEPTH; i++) begin
            rd(d);
            chk(d === ent(2'b10, 62'h200 + 62'(i)), "R2 refill order", d, ent(2'b10, 62'h200 + 62'(i)));
        end
        rd(d);
        chk(d === ent(2'b10, 62'h4444), "R5 no tag without loss", d, ent(2'b10, 62'h4444));

        // R10 disable keeps reads, R1 re-enable discards
        cap(62'h11, irq);
        cap(62'h22, irq);
        @(negedge clk); trace_en = 1'b0;
        cap(62'h33, irq);
        rd(d);
        chk(d === ent(2'b10, 62'h11), "R10 read while off", d, ent(2'b10, 62'h11));
        @(negedge clk); trace_en = 1'b1;
        idle(1);
        rd(d);
        chk(d === 64'd0, "R1 re-enable clears pointers", d, 64'd0);

        // R3 priority
        cap(62'hA0, irq);
        cap(62'hB0, irq);
        @(negedge clk);
        cap_valid = 1'b1; cap_data = 62'hC0;
        patch_req = 1'b1; patch_idx = 3'd1; patch_data = 62'hF0;
        rd_req = 1'b1;
        #1;
        chk(patch_ack === 1'b0 && rd_ack === 1'b0, "R3 capture wins",
            {62'd0, patch_ack, rd_ack}, 64'd0);
        @(negedge clk);
        cap_valid = 1'b0;
        #1;
        chk(patch_ack === 1'b1 && rd_ack === 1'b0, "R3 patch before read",
            {62'd0, patch_ack, rd_ack}, 64'd2);
        @(negedge clk);
        patch_req = 1'b0;
        #1;
        chk(rd_ack === 1'b1, "R3 read granted last", {63'd0, rd_ack}, 64'd1);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_done === 1'b1 && rd_data === ent(2'b10, 62'hA0), "R3 read result", rd_data, ent(2'b10, 62'hA0));
        rd(d);
        chk(d === ent(2'b10, 62'hF0), "R8 patched payload", d, ent(2'b10, 62'hF0));
        rd(d);
        chk(d === ent(2'b10, 62'hC0), "R3 capture stored", d, ent(2'b10, 62'hC0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule